// File: doc/BRIEF.md
# SDRAM Initialization Command Sequencer

This block drives the command pins of one rank of SDR SDRAM under software control. A host programs a configuration word (device geometry, data bus width, CAS latency and core timings), an operating mode and a refresh interval through a small write-only register port. While the mode is anything other than normal, every host access to the memory window is turned into exactly one SDRAM command of the kind the mode names. Software brings the device up by walking the modes: clock start, precharge-all, eight auto-refreshes, mode-register load, then normal operation.

Commands that need recovery time (precharge-all, auto-refresh, load-mode) are followed by NOP cycles. During those cycles a wait output holds off the host. Once the mode is normal and a non-zero interval is programmed, an internal timer requests periodic auto-refreshes. These are queued and issued as soon as the command bus is free. The block also reports the device size implied by the geometry fields. The read/write data path, bank tracking, pads and power-down handling belong to other blocks.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset the command pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111), the address is zero, `sd_clk_en` and `mem_wait` are low, and the mode is NOP.
- R2: `sd_clk_en` rises in the cycle after the first host access accepted in NOP mode and stays high from then on. Accesses in other modes before that leave it low.
- R3: An access is accepted on a clock edge where `mem_req` is high and `mem_wait` is low. Each accepted access in a non-normal mode produces exactly one command cycle of that mode, and NOP is driven on every other cycle. Mode codes are 0 normal, 1 NOP, 2 precharge-all, 3 load-mode and 4 auto-refresh, written to register select 1, bits [2:0].
- R4: Precharge-all is encoded 0010 with A10 high and bank address 0. The next command follows no sooner than max(tRP,2) cycles later, with `mem_wait` high in between.
- R5: Auto-refresh is encoded 0001, and the next command follows no sooner than max(tRC,2) cycles later.
- R6: Load-mode is encoded 0000 with bank address 0. A[6:4] carries the CAS latency, and A[3:0] is 0 (sequential burst of one). The next command follows MRD_CYC cycles later.
- R7: `dev_size_log2` equals (column code + 8) + (row code + 11) + (bank code + 1), plus 1 when the 16-bit bus bit is set and plus 2 otherwise. The configuration word, written to select 0, is laid out as: column code [1:0], row code [3:2], bank code [4], CAS [6:5], 16-bit bus [7], tWR [11:8], tRC [15:12], tRP [19:16], tRCD [23:20], tRAS [27:24], tXSR [31:28].
- R8: With mode normal and an interval T ≠ 0 written to select 2, an auto-refresh is issued every T cycles. The first one appears T+1 cycles after the interval write. No timed refresh occurs in other modes or when T = 0.
- R9: A pending timed refresh raises `mem_wait`, takes priority over host accesses, and is issued once the current timing window closes. No request is lost, even under continuous host traffic.
- R10: A mode write with a code above 4 is ignored, and the previous mode stays in force.
- R11: An accepted access in normal mode issues no command: the pins stay at NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 config, 1 mode, 2 refresh interval |
| reg_wdata | input | 32 | Register write data |
| mem_req | input | 1 | Host access to the memory window |
| mem_wait | output | 1 | Host access held off this cycle |
| dev_size_log2 | output | 6 | Log2 of device size in bytes |
| sd_clk_en | output | 1 | SDRAM clock output enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | SDRAM address bus |
| sd_ba | output | 2 | SDRAM bank address |

## Verification
The bound checker watches properties on every cycle: every command is a single cycle followed by NOP, the wait output is high whenever a command has just gone out, precharge and load-mode address bits are correct, the clock enable is sticky and starts only from a NOP-mode access, a normal-mode access stays silent, and the refresh queue never saturates. Only the bench scenarios can show the actual spacing values for tRP, tRC and the load-mode recovery, the refresh period and the first-refresh latency, that refreshes survive continuous host traffic, the size arithmetic, and that illegal mode codes and a zero interval have no effect.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_NOP    = 3'd1,
    MODE_PRECHG = 3'd2,
    MODE_LOADMR = 3'd3,
    MODE_AREF   = 3'd4
  } seq_mode_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sd_cmd_t CMD_PRE  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam sd_cmd_t CMD_AREF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam sd_cmd_t CMD_LMR  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  typedef struct packed {
    logic [3:0] t_xsr;
    logic [3:0] t_ras;
    logic [3:0] t_rcd;
    logic [3:0] t_rp;
    logic [3:0] t_rc;
    logic [3:0] t_wr;
    logic       bus16;
    logic [1:0] cas_lat;
    logic       bank_code;
    logic [1:0] row_code;
    logic [1:0] col_code;
  } seq_cfg_t;

  // Busy cycles after a command whose spacing is t (minimum spacing two).
  function automatic logic [3:0] gap_cycles(input logic [3:0] t);
    return (t < 4'd2) ? 4'd1 : t - 4'd1;
  endfunction

  function automatic logic [5:0] size_log2(input seq_cfg_t c);
    logic [5:0] s;
    s = 6'd20 + {4'd0, c.col_code} + {4'd0, c.row_code} + {5'd0, c.bank_code};
    return c.bus16 ? s + 6'd1 : s + 6'd2;
  endfunction

endpackage

// File: rtl/sdram_seq_regs.sv
module sdram_seq_regs
  import sdram_seq_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_sel,
  input  logic [31:0]        reg_wdata,
  output seq_cfg_t           cfg,
  output seq_mode_e          mode,
  output logic [TIMER_W-1:0] tr,
  output logic               tr_load
);

  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_MODE = 2'd1;
  localparam logic [1:0] SEL_TR   = 2'd2;

  logic               cfg_en, mode_en, tr_en;
  seq_cfg_t           cfg_d;
  seq_mode_e          mode_d;
  logic [TIMER_W-1:0] tr_d;

  always_comb begin
    cfg_en  = reg_wr && (reg_sel == SEL_CFG);
    tr_en   = reg_wr && (reg_sel == SEL_TR);
    mode_en = reg_wr && (reg_sel == SEL_MODE) && (reg_wdata[2:0] <= 3'd4);
    cfg_d   = seq_cfg_t'(reg_wdata);
    mode_d  = seq_mode_e'(reg_wdata[2:0]);
    tr_d    = reg_wdata[TIMER_W-1:0];
    tr_load = tr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      mode <= MODE_NOP;
      tr   <= '0;
    end else begin
      if (cfg_en)  cfg  <= cfg_d;
      if (mode_en) mode <= mode_d;
      if (tr_en)   tr   <= tr_d;
    end
  end

endmodule

// File: rtl/sdram_seq_refresh.sv
module sdram_seq_refresh #(
  parameter int TIMER_W = 16,
  parameter int PEND_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [TIMER_W-1:0] tr,
  input  logic               tr_load,
  input  logic [TIMER_W-1:0] tr_new,
  input  logic               pend_dec,
  output logic               pend_nz,
  output logic [PEND_W-1:0]  pend_cnt
);

  logic [TIMER_W-1:0] cnt_q, cnt_d, tr_m1, new_m1;
  logic [PEND_W-1:0]  pend_q, pend_d;
  logic               req;

  always_comb begin
    tr_m1  = (tr == '0) ? '0 : tr - 1'b1;
    new_m1 = (tr_new == '0) ? '0 : tr_new - 1'b1;
    req    = 1'b0;
    if (tr_load) begin
      cnt_d = new_m1;
    end else if (!run) begin
      cnt_d = tr_m1;
    end else if (cnt_q == '0) begin
      req   = 1'b1;
      cnt_d = tr_m1;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
    pend_d = pend_q + PEND_W'(req) - PEND_W'(pend_dec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend_nz  = (pend_q != '0);
  assign pend_cnt = pend_q;

endmodule

// File: rtl/sdram_seq_cmd.sv
module sdram_seq_cmd
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int MRD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_mode_e         mode,
  input  logic [3:0]        t_rp,
  input  logic [3:0]        t_rc,
  input  logic [1:0]        cas_lat,
  input  logic              mem_req,
  input  logic              pend_nz,
  output sd_cmd_t           cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              mem_wait,
  output logic              pend_dec,
  output logic              clk_en
);

  localparam logic [3:0] MRD_GAP = gap_cycles(4'(MRD_CYC));

  sd_cmd_t           cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [3:0]        busy_q, busy_d;
  logic              clk_en_q, clk_en_d;
  logic              idle, accept;

  always_comb begin
    idle     = (busy_q == 4'd0);
    mem_wait = !idle || pend_nz;
    accept   = mem_req && !mem_wait;
    pend_dec = idle && pend_nz;
    cmd_d    = CMD_NOP;
    addr_d   = '0;
    busy_d   = idle ? 4'd0 : busy_q - 4'd1;
    clk_en_d = clk_en_q;
    if (pend_dec) begin
      cmd_d  = CMD_AREF;
      busy_d = gap_cycles(t_rc);
    end else if (accept) begin
      unique case (mode)
        MODE_NOP: clk_en_d = 1'b1;
        MODE_PRECHG: begin
          cmd_d      = CMD_PRE;
          addr_d[10] = 1'b1;
          busy_d     = gap_cycles(t_rp);
        end
        MODE_AREF: begin
          cmd_d  = CMD_AREF;
          busy_d = gap_cycles(t_rc);
        end
        MODE_LOADMR: begin
          cmd_d       = CMD_LMR;
          addr_d[6:4] = {1'b0, cas_lat};
          busy_d      = MRD_GAP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= CMD_NOP;
      addr_q   <= '0;
      busy_q   <= '0;
      clk_en_q <= 1'b0;
    end else begin
      cmd_q    <= cmd_d;
      addr_q   <= addr_d;
      busy_q   <= busy_d;
      clk_en_q <= clk_en_d;
    end
  end

  assign cmd    = cmd_q;
  assign addr   = addr_q;
  assign clk_en = clk_en_q;

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int TIMER_W = 16,
  parameter int PEND_W  = 3,
  parameter int MRD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              mem_req,
  output logic              mem_wait,
  output logic [5:0]        dev_size_log2,
  output logic              sd_clk_en,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [1:0]        sd_ba
);

  logic               rst_meta_n, rst_sync_n;
  seq_cfg_t           cfg_q;
  seq_mode_e          mode_q;
  logic [TIMER_W-1:0] tr_q;
  logic               tr_load, pend_nz, pend_dec, run;
  logic [PEND_W-1:0]  pend_cnt;
  sd_cmd_t            cmd;
  logic [15:0]        cfg_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  sdram_seq_regs #(.TIMER_W(TIMER_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .cfg       (cfg_q),
    .mode      (mode_q),
    .tr        (tr_q),
    .tr_load   (tr_load)
  );

  assign run = (mode_q == MODE_NORMAL) && (tr_q != '0);

  sdram_seq_refresh #(.TIMER_W(TIMER_W), .PEND_W(PEND_W)) i_refresh (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .tr       (tr_q),
    .tr_load  (tr_load),
    .tr_new   (reg_wdata[TIMER_W-1:0]),
    .pend_dec (pend_dec),
    .pend_nz  (pend_nz),
    .pend_cnt (pend_cnt)
  );

  sdram_seq_cmd #(.ADDR_W(ADDR_W), .MRD_CYC(MRD_CYC)) i_cmd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .mode     (mode_q),
    .t_rp     (cfg_q.t_rp),
    .t_rc     (cfg_q.t_rc),
    .cas_lat  (cfg_q.cas_lat),
    .mem_req  (mem_req),
    .pend_nz  (pend_nz),
    .cmd      (cmd),
    .addr     (sd_addr),
    .mem_wait (mem_wait),
    .pend_dec (pend_dec),
    .clk_en   (sd_clk_en)
  );

  // Timings consumed by the data-path sequencer, held here for it.
  assign cfg_unused    = {cfg_q.t_xsr, cfg_q.t_ras, cfg_q.t_rcd, cfg_q.t_wr};
  assign dev_size_log2 = size_log2(cfg_q);
  assign sd_cs_n       = cmd.cs_n;
  assign sd_ras_n      = cmd.ras_n;
  assign sd_cas_n      = cmd.cas_n;
  assign sd_we_n       = cmd.we_n;
  assign sd_ba         = 2'b00;

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PEND_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_wait,
  input logic              sd_clk_en,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [1:0]        sd_ba,
  input logic [PEND_W-1:0] pend_cnt,
  input seq_mode_e         mode
);

  logic [3:0] pins;
  assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (pins != 4'b0111) |=> (pins == 4'b0111));

  a_r4_prechg_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0010) |-> (sd_addr[10] && sd_ba == 2'b00));

  a_r6_loadmr_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == 4'b0000) |-> (sd_ba == 2'b00 && sd_addr[3:0] == 4'd0 && !sd_addr[10]));

  a_r9_hold_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (pins != 4'b0111) |-> mem_wait);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt != {PEND_W{1'b1}});

  a_r2_clk_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sd_clk_en |=> sd_clk_en);

  a_r2_clk_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_clk_en) |-> $past(mem_req && !mem_wait && mode == MODE_NOP));

  a_r11_normal_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_wait && mode == MODE_NORMAL) |=> (pins == 4'b0111));

endmodule

bind sdram_cmd_seq sdram_seq_chk #(.ADDR_W(ADDR_W), .PEND_W(PEND_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .mem_req   (mem_req),
  .mem_wait  (mem_wait),
  .sd_clk_en (sd_clk_en),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_addr   (sd_addr),
  .sd_ba     (sd_ba),
  .pend_cnt  (pend_cnt),
  .mode      (mode_q)
);

// File: tb/test_sdram_cmd_seq.sv
module test_sdram_cmd_seq;

  localparam int ADDR_W = 13;

  logic              clk = 1'b0;
  logic              rst_n, reg_wr, mem_req, mem_wait, sd_clk_en;
  logic [1:0]        reg_sel, sd_ba;
  logic [31:0]       reg_wdata;
  logic [5:0]        dev_size_log2;
  logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [ADDR_W-1:0] sd_addr;
  logic [3:0]        pins;
  int                checks = 0;
  int                errors = 0;

  always #5 clk = ~clk;
  assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  sdram_cmd_seq i_sdram_cmd_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_wait(mem_wait),
    .dev_size_log2(dev_size_log2), .sd_clk_en(sd_clk_en), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_ba(sd_ba)
  );

  // cfg: txsr 8, tras 5, trcd 3, trp 3, trc 7, twr 2, bus16, cas 3, bank 1, row 2, col 1
  localparam logic [31:0] CFG_A = 32'h8533_72F9;
  localparam logic [31:0] CFG_B = 32'h8533_7260;

  // {mode, expected pins, expected spacing}
  localparam logic [11:0] VEC [12] = '{
    {3'd1, 4'b0111, 5'd1}, {3'd2, 4'b0010, 5'd3},
    {3'd4, 4'b0001, 5'd7}, {3'd4, 4'b0001, 5'd7},
    {3'd4, 4'b0001, 5'd7}, {3'd4, 4'b0001, 5'd7},
    {3'd4, 4'b0001, 5'd7}, {3'd4, 4'b0001, 5'd7},
    {3'd4, 4'b0001, 5'd7}, {3'd4, 4'b0001, 5'd7},
    {3'd3, 4'b0000, 5'd2}, {3'd0, 4'b0111, 5'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Entered at a negedge; returns pins/address of the command and its spacing.
  task automatic access(output logic [3:0] c, output logic [ADDR_W-1:0] a, output int gap);
    mem_req = 1'b1;
    while (mem_wait) @(negedge clk);
    @(negedge clk);
    mem_req = 1'b0;
    c = pins; a = sd_addr; gap = 1;
    while (mem_wait && gap < 40) begin gap++; @(negedge clk); end
  endtask

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R6";
      3'd4: return "R5";
      default: return "R11";
    endcase
  endfunction

  initial begin
    repeat (30000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0]        c;
    logic [ADDR_W-1:0] a;
    int                gap, first, last, nref;
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0; mem_req = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 pins", 32'(pins), 32'h7);
    check("R1 addr", 32'(sd_addr), 32'h0);
    check("R1 clk_en", 32'(sd_clk_en), 32'h0);
    check("R1 mem_wait", 32'(mem_wait), 32'h0);
    access(c, a, gap);
    check("R1 reset mode is NOP", 32'(c), 32'h7);
    check("R1 no clock before NOP mode access? (NOP mode starts it)", 32'(sd_clk_en), 32'h1);

    // Reset again to test clock gating from the start
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; repeat (4) @(negedge clk);

    // R7 geometry
    reg_write(2'd0, CFG_B);
    check("R7 size 32-bit min geometry", 32'(dev_size_log2), 32'd22);
    reg_write(2'd0, CFG_A);
    check("R7 size 16-bit", 32'(dev_size_log2), 32'd25);

    // R2: precharge before any NOP access leaves clock off; R10 illegal mode ignored
    reg_write(2'd1, 32'd2);
    access(c, a, gap);
    check("R4 pins", 32'(c), 32'h2);
    check("R2 clock stays off", 32'(sd_clk_en), 32'h0);
    reg_write(2'd1, 32'd6);
    access(c, a, gap);
    check("R10 mode kept after code 6", 32'(c), 32'h2);
    reg_write(2'd1, 32'd7);
    access(c, a, gap);
    check("R10 mode kept after code 7", 32'(c), 32'h2);

    // Init sequence table
    for (int i = 0; i < 12; i++) begin
      reg_write(2'd1, {29'd0, VEC[i][11:9]});
      access(c, a, gap);
      check({tag_of(VEC[i][11:9]), " R3 command"}, 32'(c), 32'(VEC[i][8:5]));
      check({tag_of(VEC[i][11:9]), " spacing"}, 32'(gap), 32'(VEC[i][4:0]));
      if (VEC[i][11:9] == 3'd1) check("R2 clock on", 32'(sd_clk_en), 32'h1);
      if (VEC[i][11:9] == 3'd2) check("R4 A10", 32'(a), 32'h400);
      if (VEC[i][11:9] == 3'd3) check("R6 mode address", 32'(a), 32'h30);
      if (VEC[i][11:9] == 3'd4) check("R5 address", 32'(a), 32'h0);
    end
    check("R11 no wait after normal access", 32'(mem_wait), 32'h0);
    check("R2 clock sticky", 32'(sd_clk_en), 32'h1);

    // R8 timed refresh, interval 40
    reg_write(2'd2, 32'd40);
    first = -1;
    for (int i = 0; i < 60; i++) begin
      if (pins == 4'b0001 && first < 0) first = i;
      @(negedge clk);
    end
    check("R8 first refresh latency", 32'(first), 32'd41);

    // R9 continuous host traffic, refreshes still every 40 cycles
    while (pins != 4'b0001) @(negedge clk);
    mem_req = 1'b1;
    last = 0; nref = 0;
    for (int i = 1; i <= 400; i++) begin
      @(negedge clk);
      if (pins == 4'b0001) begin
        nref++;
        check("R9 wait during refresh", 32'(mem_wait), 32'h1);
        check("R8 refresh spacing", 32'(i - last), 32'd40);
        last = i;
      end
    end
    mem_req = 1'b0;
    check("R9 refresh count under traffic", 32'(nref), 32'd10);

    // R8 no refresh outside normal mode
    reg_write(2'd1, 32'd1);
    nref = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pins == 4'b0001) nref++;
    end
    check("R8 no refresh in NOP mode", 32'(nref), 32'd0);

    // R8 no refresh with zero interval
    reg_write(2'd2, 32'd0);
    reg_write(2'd1, 32'd0);
    nref = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pins == 4'b0001) nref++;
    end
    check("R8 no refresh with zero interval", 32'(nref), 32'd0);

    // R11 normal access silent
    access(c, a, gap);
    check("R11 normal access pins", 32'(c), 32'h7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule